// File: doc/BRIEF.md
# SDRAM Burst Write Sequencer

This block performs one SDRAM write access of any number of 16-bit halfwords (at least one). Row address, column address and write data all travel on one shared 16-bit output bus. A request supplies a row, a starting column and a halfword count. The write data then arrives one halfword per clock through a valid/ready stream.

The access follows a fixed order:

1. Activate with the row on the bus.
2. NOP cycles until the write gap has elapsed and the first halfword is valid.
3. A write command carrying the column minus one, with both byte masks high, so the SDRAM drops that beat.
4. One data beat per halfword with the masks low.
5. A burst-terminate command.
6. A deselected idle cycle.

Because the bus is shared, the column is presented one lower than the requested address. The real data is therefore written from the requested column onwards. The burst length is set by the terminate command rather than by a programmed length.

Top module: `sdram_wr_seq`

## Requirements
- R1: After reset, cs_n is 1 (deselected), cke is 1, both masks are 1, busy, done and wd_ready are 0, and req_ready is 1.
- R2: In idle, a request with req_valid=1 and req_len not 0 is accepted on the clock edge. The next cycle is Activate (cs_n=0, ras_n=0, cas_n=1, we_n=1) with req_row on the bus. A request with req_len=0 is ignored.
- R3: Each cycle after Activate is a NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1) until the write command is issued. The write command (cs_n=0, ras_n=1, cas_n=0, we_n=0) comes ACT_TO_WR cycles after Activate when wd_valid is already high; otherwise it waits for the first cycle in which wd_valid is high.
- R4: During the write command, the bus carries req_col minus one, modulo 2^16 (column 0 gives 16'hFFFF).
- R5: During the write command, both masks are 1 and wd_ready is 0.
- R6: Exactly req_len data beats follow the write command. Each beat is a NOP command with wd_ready=1 and wd_data on the bus. Both masks are 0 when wd_valid is 1 and both are 1 when wd_valid is 0. wd_ready is 0 in every other cycle.
- R7: The cycle after the last data beat is a burst terminate (cs_n=0, ras_n=1, cas_n=1, we_n=0) with both masks 1. done is 1 in that cycle only.
- R8: The cycle after burst terminate has cs_n=1 and busy=1. A request presented in that cycle is not accepted.
- R9: busy is 1 from the cycle after acceptance through the idle cycle of R8, and req_ready is its inverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken (idle) |
| req_row | input | 16 | Row address |
| req_col | input | 16 | First column to write |
| req_len | input | CNT_W | Halfword count (0 ignored) |
| wd_valid | input | 1 | Write halfword present |
| wd_ready | output | 1 | Halfword consumed this cycle (data beat) |
| wd_data | input | 16 | Write halfword |
| busy | output | 1 | Access in progress, including the trailing idle cycle |
| done | output | 1 | Pulse on the burst-terminate cycle |
| mem_cke | output | 1 | Clock enable, always high |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dqm_hi | output | 1 | Upper byte mask (1 = masked) |
| mem_dqm_lo | output | 1 | Lower byte mask (1 = masked) |
| mem_ad | output | 16 | Shared address/data bus |

## Verification
The bench sweeps burst lengths from 1 to 40 and walks the column through 0, 1, 16'hFFFF and assorted values. This separates an off-by-one in the beat count and an unwrapped column decrement from correct behaviour. Runs with first-data delays of 0 to 3 cycles show whether the write command is gated on data validity or issued on a fixed schedule. A burst with a missing halfword shows that the masks follow wd_valid per beat. A request held during the trailing idle cycle, and a request with a count of zero, show that neither starts an access.

// File: rtl/sdram_wr_pkg.sv
package sdram_wr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ACT, ST_WAIT, ST_WCMD, ST_DATA, ST_BST, ST_GAP
  } seq_st_t;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sd_cmd_t;

  localparam sd_cmd_t CMD_DESEL = 4'b1111;
  localparam sd_cmd_t CMD_NOP   = 4'b0111;
  localparam sd_cmd_t CMD_ACT   = 4'b0011;
  localparam sd_cmd_t CMD_WRITE = 4'b0100;
  localparam sd_cmd_t CMD_BST   = 4'b0110;
endpackage

// File: rtl/sdram_wr_fsm.sv
module sdram_wr_fsm
  import sdram_wr_pkg::*;
#(
  parameter int AD_W      = 16,
  parameter int CNT_W     = 8,
  parameter int ACT_TO_WR = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [AD_W-1:0]  req_row,
  input  logic [AD_W-1:0]  req_col,
  input  logic [CNT_W-1:0] req_len,
  input  logic             wd_valid,
  output seq_st_t          st,
  output logic [AD_W-1:0]  row_q,
  output logic [AD_W-1:0]  col_q,
  output logic             acc_fire,
  output logic             last_beat
);
  localparam int WC_W = (ACT_TO_WR > 2) ? $clog2(ACT_TO_WR) : 1;
  localparam logic [WC_W-1:0] WC_LOAD = WC_W'(ACT_TO_WR - 2);

  logic [WC_W-1:0]  wcnt;
  logic [CNT_W-1:0] rem;

  assign acc_fire  = (st == ST_IDLE) && req_valid && (req_len != '0);
  assign last_beat = (st == ST_DATA) && (rem == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      row_q <= '0;
      col_q <= '0;
      wcnt  <= '0;
      rem   <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (acc_fire) begin
          st    <= ST_ACT;
          row_q <= req_row;
          col_q <= req_col;
          rem   <= req_len - 1'b1;
        end
        ST_ACT: begin
          st   <= ST_WAIT;
          wcnt <= WC_LOAD;
        end
        ST_WAIT: begin
          if (wcnt != '0)    wcnt <= wcnt - 1'b1;
          else if (wd_valid) st   <= ST_WCMD;
        end
        ST_WCMD: st <= ST_DATA;
        ST_DATA: begin
          if (rem == '0) st  <= ST_BST;
          else           rem <= rem - 1'b1;
        end
        ST_BST:  st <= ST_GAP;
        ST_GAP:  st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_LEN_ZERO_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && req_valid && req_len == '0) |=> st == ST_IDLE); // R2
  AST_WAIT_FOR_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT && wcnt == '0 && !wd_valid) |=> st == ST_WAIT); // R3
  AST_ACT_THEN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_ACT |=> (st == ST_WAIT && wcnt == WC_LOAD)); // R3
  AST_GAP_AFTER_BST: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_BST |=> st == ST_GAP); // R8
endmodule

// File: rtl/sdram_wr_pins.sv
module sdram_wr_pins
  import sdram_wr_pkg::*;
#(
  parameter int AD_W = 16
) (
  input  seq_st_t         st,
  input  logic [AD_W-1:0] row_q,
  input  logic [AD_W-1:0] col_q,
  input  logic            wd_valid,
  input  logic [AD_W-1:0] wd_data,
  output sd_cmd_t         cmd,
  output logic [1:0]      dqm,
  output logic [AD_W-1:0] ad,
  output logic            wd_ready,
  output logic            done,
  output logic            busy
);
  function automatic logic [AD_W-1:0] col_before(input logic [AD_W-1:0] c);
    return c - 1'b1;
  endfunction

  always_comb begin
    cmd      = CMD_NOP;
    dqm      = 2'b11;
    ad       = '0;
    wd_ready = 1'b0;
    done     = 1'b0;
    busy     = (st != ST_IDLE);
    unique case (st)
      ST_IDLE, ST_GAP: cmd = CMD_DESEL;
      ST_ACT: begin
        cmd = CMD_ACT;
        ad  = row_q;
      end
      ST_WAIT: cmd = CMD_NOP;
      ST_WCMD: begin
        cmd = CMD_WRITE;
        ad  = col_before(col_q);
      end
      ST_DATA: begin
        wd_ready = 1'b1;
        ad       = wd_data;
        dqm      = wd_valid ? 2'b00 : 2'b11;
      end
      ST_BST: begin
        cmd  = CMD_BST;
        done = 1'b1;
      end
      default: cmd = CMD_DESEL;
    endcase
  end
endmodule

// File: rtl/sdram_wr_seq.sv
module sdram_wr_seq
  import sdram_wr_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int ACT_TO_WR = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [15:0]      req_row,
  input  logic [15:0]      req_col,
  input  logic [CNT_W-1:0] req_len,
  input  logic             wd_valid,
  output logic             wd_ready,
  input  logic [15:0]      wd_data,
  output logic             busy,
  output logic             done,
  output logic             mem_cke,
  output logic             mem_cs_n,
  output logic             mem_ras_n,
  output logic             mem_cas_n,
  output logic             mem_we_n,
  output logic             mem_dqm_hi,
  output logic             mem_dqm_lo,
  output logic [15:0]      mem_ad
);
  localparam int AD_W = 16;

  seq_st_t         st;
  logic [AD_W-1:0] row_q, col_q;
  logic            acc_fire, last_beat;
  sd_cmd_t         cmd;
  logic [1:0]      dqm;

  sdram_wr_fsm #(.AD_W(AD_W), .CNT_W(CNT_W), .ACT_TO_WR(ACT_TO_WR)) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_row(req_row),
    .req_col(req_col), .req_len(req_len), .wd_valid(wd_valid), .st(st),
    .row_q(row_q), .col_q(col_q), .acc_fire(acc_fire), .last_beat(last_beat)
  );

  sdram_wr_pins #(.AD_W(AD_W)) u_pins (
    .st(st), .row_q(row_q), .col_q(col_q), .wd_valid(wd_valid),
    .wd_data(wd_data), .cmd(cmd), .dqm(dqm), .ad(mem_ad),
    .wd_ready(wd_ready), .done(done), .busy(busy)
  );

  assign req_ready  = ~busy;
  assign mem_cke    = 1'b1;
  assign mem_cs_n   = cmd.cs_n;
  assign mem_ras_n  = cmd.ras_n;
  assign mem_cas_n  = cmd.cas_n;
  assign mem_we_n   = cmd.we_n;
  assign mem_dqm_hi = dqm[1];
  assign mem_dqm_lo = dqm[0];

  logic wr_cmd_evt, bst_evt, act_evt;
  assign wr_cmd_evt = !mem_cs_n && mem_ras_n && !mem_cas_n && !mem_we_n;
  assign bst_evt    = !mem_cs_n && mem_ras_n && mem_cas_n && !mem_we_n;
  assign act_evt    = !mem_cs_n && !mem_ras_n && mem_cas_n && mem_we_n;

  AST_ACCEPT_TO_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire |=> (act_evt && mem_ad == $past(req_row))); // R2
  AST_WRITE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmd_evt |-> (mem_dqm_hi && mem_dqm_lo && !wd_ready)); // R5
  AST_READY_ON_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    wd_ready |-> (!mem_cs_n && mem_ras_n && mem_cas_n && mem_we_n)); // R6
  AST_BST_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |=> (bst_evt && done && mem_dqm_hi && mem_dqm_lo)); // R7
  AST_IDLE_AFTER_BST: assert property (@(posedge clk) disable iff (!rst_n)
    bst_evt |=> (mem_cs_n && busy)); // R8
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready); // R9
endmodule

// File: tb/test_sdram_wr_seq.sv
module test_sdram_wr_seq;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [15:0] req_row = '0, req_col = '0;
  logic [CNT_W-1:0] req_len = '0;
  logic wd_valid = 1'b0;
  logic [15:0] wd_data = '0;
  logic req_ready, wd_ready, busy, done;
  logic mem_cke, mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n, mem_dqm_hi, mem_dqm_lo;
  logic [15:0] mem_ad;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  sdram_wr_seq #(.CNT_W(CNT_W), .ACT_TO_WR(2)) i_sdram_wr_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_row(req_row), .req_col(req_col), .req_len(req_len),
    .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_data(wd_data),
    .busy(busy), .done(done), .mem_cke(mem_cke), .mem_cs_n(mem_cs_n),
    .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n),
    .mem_dqm_hi(mem_dqm_hi), .mem_dqm_lo(mem_dqm_lo), .mem_ad(mem_ad)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] pins();
    return {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n};
  endfunction

  function automatic logic [15:0] pat(input logic [15:0] r, input logic [15:0] c,
                                      input int j);
    return (r ^ 16'hA5C3) + c + 16'(j) * 16'h0107;
  endfunction

  task automatic access(input logic [15:0] row, input logic [15:0] col,
                        input int n, input int delay, input bit gap, input bit poke);
    logic [15:0] exp_col;
    exp_col = col - 16'd1;
    @(negedge clk);
    chk(req_ready && !busy && mem_cs_n, "R9 idle before request", {busy, mem_cs_n}, 32'h1);
    req_valid = 1'b1; req_row = row; req_col = col; req_len = CNT_W'(n);
    wd_valid = 1'b0;
    @(posedge clk); #1 req_valid = 1'b0;
    @(negedge clk);
    chk(pins() == 4'b0011, "R2 activate command", pins(), 4'b0011);
    chk(mem_ad == row, "R2 row on bus", mem_ad, row);
    chk(busy && !req_ready, "R9 busy after accept", {busy, req_ready}, 32'h2);
    for (int i = 0; i <= delay; i++) begin
      @(posedge clk); #1 wd_valid = (i == delay); wd_data = pat(row, col, 0);
      @(negedge clk);
      chk(pins() == 4'b0111 && !wd_ready, "R3 nop before write", {wd_ready, pins()}, 4'b0111);
    end
    @(posedge clk); #1;
    @(negedge clk);
    chk(pins() == 4'b0100, "R3 write command timing", pins(), 4'b0100);
    chk(mem_ad == exp_col, "R4 column minus one", mem_ad, exp_col);
    chk(mem_dqm_hi && mem_dqm_lo && !wd_ready, "R5 write beat masked",
        {wd_ready, mem_dqm_hi, mem_dqm_lo}, 32'h3);
    for (int j = 0; j < n; j++) begin
      @(posedge clk); #1 wd_data = pat(row, col, j); wd_valid = !(gap && j == 1);
      @(negedge clk);
      chk(pins() == 4'b0111 && wd_ready && !done, "R6 data beat nop/ready",
          {done, wd_ready, pins()}, 32'h17);
      chk(mem_ad == pat(row, col, j), "R6 data on bus", mem_ad, pat(row, col, j));
      if (gap && j == 1)
        chk(mem_dqm_hi && mem_dqm_lo, "R6 invalid beat masked", {mem_dqm_hi, mem_dqm_lo}, 32'h3);
      else
        chk(!mem_dqm_hi && !mem_dqm_lo, "R6 valid beat unmasked", {mem_dqm_hi, mem_dqm_lo}, 32'h0);
    end
    @(posedge clk); #1 wd_valid = 1'b0;
    @(negedge clk);
    chk(pins() == 4'b0110, "R7 burst terminate", pins(), 4'b0110);
    chk(done && !wd_ready && mem_dqm_hi && mem_dqm_lo, "R7 done pulse and masks",
        {done, wd_ready, mem_dqm_hi, mem_dqm_lo}, 32'hB);
    @(posedge clk); #1 if (poke) begin req_valid = 1'b1; req_len = CNT_W'(1); end
    @(negedge clk);
    chk(mem_cs_n && busy && !req_ready && !done, "R8 idle gap cycle",
        {done, req_ready, busy, mem_cs_n}, 32'h3);
    @(posedge clk); #1;
    @(negedge clk);
    chk(mem_cs_n && !busy && !done, "R8 gap request not taken", {done, busy, mem_cs_n}, 32'h1);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(mem_cs_n && mem_cke && mem_dqm_hi && mem_dqm_lo, "R1 reset pins",
        {mem_cs_n, mem_cke, mem_dqm_hi, mem_dqm_lo}, 32'hF);
    chk(!busy && !done && !wd_ready && req_ready, "R1 reset handshake",
        {busy, done, wd_ready, req_ready}, 32'h1);
    rst_n = 1'b1;
    @(negedge clk);
    req_valid = 1'b1; req_len = '0; req_row = 16'h1234;
    @(posedge clk); #1 req_valid = 1'b0;
    @(negedge clk);
    chk(!busy && mem_cs_n, "R2 zero length ignored", {busy, mem_cs_n}, 32'h1);
    access(16'h0001, 16'h0000, 1, 0, 1'b0, 1'b0);
    access(16'hFFFF, 16'h0001, 2, 0, 1'b1, 1'b1);
    access(16'h0100, 16'hFFFF, 3, 2, 1'b0, 1'b1);
    for (int n = 1; n <= 40; n++)
      access(16'(n * 16'h0313), 16'(n * 16'h1021), n, n % 4, (n % 7) == 3, (n % 2) == 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule